// File: doc/BRIEF.md
# Temperature-tracking fan PWM controller

This block closes a slow thermal loop around a cooling fan. A temperature reading arrives as a digital sample with a valid strobe. On every update tick the block compares the most recent sample against a programmed setpoint. It then moves an 8-bit speed level up by a programmable step when the reading is too hot and down by that step when it is too cool. The level holds when the reading equals the setpoint. After each move the level is clamped between a programmable floor and a programmable ceiling. The floor keeps the fan turning.

The interval between ticks is programmable, so a full sweep of the speed range can be made to take a long time. The speed level drives a single pulse-width-modulated output meant for one switching transistor. A tachometer input is watched. If the fan is commanded on and no tach pulse arrives within a programmable window, a sticky stall fault is raised so that the system can shut down. Parameters are loaded through a simple write port.

Top module: `fan_speed_ctrl`

## Requirements
- R1: While rst_ni is low, level_o equals the maximum-level default (224), stall_o is 0 and every parameter returns to its default: setpoint 80, step 8, floor 32, ceiling 224, tick interval 16 cycles, stall window 1000 cycles.
- R2: At an update tick the level rises by the step if the latched sample is greater than the setpoint, falls by the step if the sample is smaller, and holds if they are equal. Comparisons are unsigned over 16 bits.
- R3: Until the first sample has been accepted (temp_valid_i high at a clock edge) after reset, ticks do not move the level.
- R4: After each tick the level is first raised to the floor if below it, then lowered to the ceiling if above it, so the ceiling wins when floor exceeds ceiling. Arithmetic saturates at 0 and 255.
- R5: The level changes only at update ticks. Ticks occur every N clock cycles, with N the active interval and an interval of 0 acting as 1. The first tick comes 16 cycles after reset release.
- R6: A write (cfg_we_i high) stores cfg_wdata_i by address: 0 setpoint, 1 step, 2 limits with bits [15:8] ceiling and [7:0] floor, 3 tick interval, 4 stall window; addresses 5 to 7 are ignored. A written value takes effect at the next update tick and not before.
- R7: pwm_o is high for exactly level_o cycles out of every 256-cycle frame, so level 0 keeps it low.
- R8: tach_i passes through a two-flop synchroniser; while the level is nonzero, stall_o is set once no rising tach edge has been seen for the stall window.
- R9: stall_o stays set until fault_clr_i is pulsed, even if tach pulses return, and it is never raised while the level is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| temp_valid_i | input | 1 | Temperature sample strobe |
| temp_i | input | 16 | Temperature sample, unsigned |
| cfg_we_i | input | 1 | Parameter write enable |
| cfg_addr_i | input | 3 | Parameter address |
| cfg_wdata_i | input | 16 | Parameter write data |
| tach_i | input | 1 | Fan tachometer, asynchronous |
| fault_clr_i | input | 1 | Clears the stall fault |
| pwm_o | output | 1 | PWM drive to the fan transistor |
| level_o | output | 8 | Current speed level |
| stall_o | output | 1 | Sticky stall fault |

## Verification
The regulation loop is driven with readings above, below and exactly at the setpoint, including the extremes 0 and 65535. This separates the up, down and hold decisions, and shows that one tick moves the level by exactly one step. Large steps against the floor and the ceiling distinguish clamping from wrap-around, and a floor raised above a held level shows that clamping also applies without a move. Writing a new interval in mid-period shows whether it is applied early or late. Stopping and restarting the tach, at a nonzero level and at level 0, separates a real stall from the idle case and shows that the fault is sticky.

// File: rtl/fan_pkg.sv
package fan_pkg;
  localparam int TEMP_W = 16;
  localparam int CFG_W  = 16;
  localparam int LVL_W  = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SETPOINT = 3'd0,
    A_STEP     = 3'd1,
    A_LIMITS   = 3'd2,
    A_INTERVAL = 3'd3,
    A_TIMEOUT  = 3'd4
  } cfg_addr_e;

  typedef struct packed {
    logic [TEMP_W-1:0] setpoint;
    logic [CFG_W-1:0]  step;
    logic [LVL_W-1:0]  lvl_max;
    logic [LVL_W-1:0]  lvl_min;
    logic [CFG_W-1:0]  interval;
    logic [CFG_W-1:0]  timeout;
  } fan_cfg_t;
endpackage

// File: rtl/fan_cfg_regs.sv
module fan_cfg_regs
  import fan_pkg::*;
#(
  parameter fan_cfg_t RST_CFG = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              tick_i,
  output fan_cfg_t          shadow_o,
  output logic [CFG_W-1:0]  interval_o,
  output logic [CFG_W-1:0]  timeout_o
);
  fan_cfg_t sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= RST_CFG;
    end else if (we_i) begin
      case (cfg_addr_e'(addr_i))
        A_SETPOINT: sh_q.setpoint <= wdata_i;
        A_STEP:     sh_q.step     <= wdata_i;
        A_LIMITS:   {sh_q.lvl_max, sh_q.lvl_min} <= wdata_i;
        A_INTERVAL: sh_q.interval <= wdata_i;
        A_TIMEOUT:  sh_q.timeout  <= wdata_i;
        default: ;
      endcase
    end
  end

  // timing parameters switch over only at a tick
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      interval_o <= RST_CFG.interval;
      timeout_o  <= RST_CFG.timeout;
    end else if (tick_i) begin
      interval_o <= sh_q.interval;
      timeout_o  <= sh_q.timeout;
    end
  end

  assign shadow_o = sh_q;
endmodule

// File: rtl/fan_level_ctrl.sv
module fan_level_ctrl
  import fan_pkg::*;
#(
  parameter logic [LVL_W-1:0] RST_LEVEL = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              temp_valid_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic [CFG_W-1:0]  interval_i,
  input  logic [TEMP_W-1:0] setpoint_i,
  input  logic [CFG_W-1:0]  step_i,
  input  logic [LVL_W-1:0]  lvl_min_i,
  input  logic [LVL_W-1:0]  lvl_max_i,
  output logic              tick_o,
  output logic              seen_o,
  output logic [TEMP_W-1:0] sample_o,
  output logic [LVL_W-1:0]  level_o
);
  localparam int WW = CFG_W + 1;

  logic [CFG_W-1:0] ival_q;
  logic [WW-1:0]    lvl_w, up_w, dn_w, mv_w, lo_w;
  logic [LVL_W-1:0] lvl_d;
  logic             hot, cold;

  assign tick_o = ({1'b0, ival_q} + WW'(1)) >= {1'b0, interval_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ival_q <= '0;
    else if (tick_o) ival_q <= '0;
    else             ival_q <= ival_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      seen_o   <= 1'b0;
    end else if (temp_valid_i) begin
      sample_o <= temp_i;
      seen_o   <= 1'b1;
    end
  end

  always_comb begin
    hot   = seen_o && (sample_o > setpoint_i);
    cold  = seen_o && (sample_o < setpoint_i);
    lvl_w = WW'(level_o);
    up_w  = lvl_w + {1'b0, step_i};
    dn_w  = ({1'b0, step_i} > lvl_w) ? '0 : lvl_w - {1'b0, step_i};
    mv_w  = hot ? up_w : (cold ? dn_w : lvl_w);
    lo_w  = (mv_w < WW'(lvl_min_i)) ? WW'(lvl_min_i) : mv_w;
    lvl_d = (lo_w > WW'(lvl_max_i)) ? lvl_max_i : lo_w[LVL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     level_o <= RST_LEVEL;
    else if (tick_o) level_o <= lvl_d;
  end
endmodule

// File: rtl/fan_pwm_gen.sv
module fan_pwm_gen
  import fan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  output logic             pwm_o
);
  logic [LVL_W-1:0] frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      pwm_o   <= 1'b0;
    end else begin
      frame_q <= frame_q + 1'b1;
      pwm_o   <= frame_q < level_i;  // registered for a glitch-free gate drive
    end
  end
endmodule

// File: rtl/fan_tach_mon.sv
module fan_tach_mon
  import fan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tach_i,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [CFG_W-1:0] timeout_i,
  output logic             stall_o
);
  logic [2:0]       sync_q;
  logic [CFG_W-1:0] quiet_q;
  logic             rise;

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tach_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q <= '0;
      stall_o <= 1'b0;
    end else begin
      if (clr_i || rise || !run_i) quiet_q <= '0;
      else if (quiet_q != '1)      quiet_q <= quiet_q + 1'b1;

      if (clr_i)                                 stall_o <= 1'b0;
      else if (run_i && !rise && quiet_q >= timeout_i) stall_o <= 1'b1;
    end
  end
endmodule

// File: rtl/fan_speed_ctrl.sv
module fan_speed_ctrl
  import fan_pkg::*;
#(
  parameter logic [TEMP_W-1:0] DEF_SETPOINT = 16'd80,
  parameter logic [CFG_W-1:0]  DEF_STEP     = 16'd8,
  parameter logic [LVL_W-1:0]  DEF_MIN      = 8'd32,
  parameter logic [LVL_W-1:0]  DEF_MAX      = 8'd224,
  parameter logic [CFG_W-1:0]  DEF_INTERVAL = 16'd16,
  parameter logic [CFG_W-1:0]  DEF_TIMEOUT  = 16'd1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              temp_valid_i,
  input  logic [TEMP_W-1:0] temp_i,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              tach_i,
  input  logic              fault_clr_i,
  output logic              pwm_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              stall_o
);
  localparam fan_cfg_t RST_CFG = '{
    setpoint: DEF_SETPOINT, step: DEF_STEP, lvl_max: DEF_MAX,
    lvl_min: DEF_MIN, interval: DEF_INTERVAL, timeout: DEF_TIMEOUT};

  fan_cfg_t          cfg_sh;
  logic [CFG_W-1:0]  act_interval, act_timeout;
  logic              tick, seen;
  logic [TEMP_W-1:0] sample;

  fan_cfg_regs #(.RST_CFG(RST_CFG)) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .tick_i(tick), .shadow_o(cfg_sh),
    .interval_o(act_interval), .timeout_o(act_timeout)
  );

  fan_level_ctrl #(.RST_LEVEL(DEF_MAX)) u_lvl (
    .clk_i, .rst_ni, .temp_valid_i, .temp_i,
    .interval_i(act_interval), .setpoint_i(cfg_sh.setpoint),
    .step_i(cfg_sh.step), .lvl_min_i(cfg_sh.lvl_min), .lvl_max_i(cfg_sh.lvl_max),
    .tick_o(tick), .seen_o(seen), .sample_o(sample), .level_o(level_o)
  );

  fan_pwm_gen u_pwm (.clk_i, .rst_ni, .level_i(level_o), .pwm_o(pwm_o));

  fan_tach_mon u_tach (
    .clk_i, .rst_ni, .tach_i, .run_i(level_o != '0), .clr_i(fault_clr_i),
    .timeout_i(act_timeout), .stall_o(stall_o)
  );
endmodule

// File: rtl/fan_speed_ctrl_chk.sv
module fan_speed_ctrl_chk
  import fan_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              seen_i,
  input logic [TEMP_W-1:0] sample_i,
  input fan_cfg_t          cfg_i,
  input logic [LVL_W-1:0]  level_i,
  input logic              pwm_i,
  input logic              stall_i,
  input logic              clr_i
);
  assert_hold_at_setpoint_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && seen_i && sample_i == cfg_i.setpoint &&
     level_i >= cfg_i.lvl_min && level_i <= cfg_i.lvl_max) |=> $stable(level_i));

  assert_level_in_limits_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cfg_i.lvl_min <= cfg_i.lvl_max) |=>
      (level_i >= $past(cfg_i.lvl_min) && level_i <= $past(cfg_i.lvl_max)));

  assert_no_move_between_ticks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(level_i));

  assert_pwm_off_at_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(level_i) == '0) |-> !pwm_i);

  assert_stall_needs_drive_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stall_i) |-> $past(level_i) != '0);

  assert_stall_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_i && !clr_i) |=> stall_i);
endmodule

bind fan_speed_ctrl fan_speed_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .seen_i(seen),
  .sample_i(sample), .cfg_i(cfg_sh), .level_i(level_o), .pwm_i(pwm_o),
  .stall_i(stall_o), .clr_i(fault_clr_i)
);

// File: tb/fan_speed_ctrl_bench.sv
module fan_speed_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        temp_valid_i = 1'b0;
  logic [15:0] temp_i = '0;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        tach_i = 1'b0;
  logic        fault_clr_i = 1'b0;
  logic        pwm_o;
  logic [7:0]  level_o;
  logic        stall_o;

  int  n_chk = 0, n_err = 0;
  bit  done = 1'b0;
  bit  tach_en = 1'b1;

  always #4 clk_i = ~clk_i;

  fan_speed_ctrl u_fan_speed_ctrl (.*);

  // one tick per entry, setpoint 80, step 8, limits 32..224
  localparam logic [15:0] VT [8] = '{16'd90, 16'd70, 16'd70, 16'd80,
                                     16'd81, 16'd79, 16'd0, 16'd65535};
  localparam logic [7:0]  VL [8] = '{8'd224, 8'd216, 8'd208, 8'd208,
                                     8'd216, 8'd208, 8'd200, 8'd208};

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step_edges(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic pwm_count(output int hi);
    hi = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk_i);
      if (pwm_o) hi++;
    end
  endtask

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk_i);
      if (tach_en) begin
        tc++;
        if (tc == 20) begin tc = 0; tach_i = ~tach_i; end
      end
    end
  end

  initial begin
    step_edges(100000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int hi;
    step_edges(3);
    check("R1 reset level", level_o, 224);
    check("R1 reset stall", stall_o, 0);
    rst_ni = 1'b1;                       // edge count starts here
    step_edges(24);
    check("R3 no sample no move", level_o, 224);
    temp_valid_i = 1'b1;

    for (int i = 0; i < 8; i++) begin
      temp_i = VT[i];
      step_edges(16);
      check($sformatf("R2 vector %0d", i), level_o, VL[i]);
    end

    // step 100, floor 40; applied at next tick
    wr(3'd1, 16'd100);
    wr(3'd2, {8'd224, 8'd40});
    temp_i = 16'd0;
    step_edges(4);
    check("R6 write not applied before tick", level_o, 208);
    step_edges(10);
    check("R6 new step applied", level_o, 108);
    step_edges(16);
    check("R4 floor clamp", level_o, 40);
    step_edges(16);
    check("R4 no underflow", level_o, 40);

    // interval 16 -> 4, applied at next tick
    temp_i = 16'd65535;
    wr(3'd3, 16'd4);
    step_edges(3);
    check("R5 level held mid-interval", level_o, 40);
    step_edges(6);
    check("R5 one tick after write", level_o, 140);
    step_edges(4);
    check("R4 ceiling clamp at new rate", level_o, 224);

    pwm_count(hi);
    check("R7 duty at 224", hi, 224);

    check("R8 no stall while tach runs", stall_o, 0);
    tach_en = 1'b0;
    step_edges(900);
    check("R8 no stall inside window", stall_o, 0);
    step_edges(200);
    check("R8 stall after window", stall_o, 1);
    tach_en = 1'b1;
    step_edges(100);
    check("R9 stall sticky", stall_o, 1);
    fault_clr_i = 1'b1;
    step_edges(1);
    fault_clr_i = 1'b0;
    step_edges(2);
    check("R9 stall cleared", stall_o, 0);

    wr(3'd2, {8'd224, 8'd0});
    wr(3'd1, 16'd255);
    temp_i = 16'd0;
    step_edges(40);
    check("R4 saturate to zero", level_o, 0);
    pwm_count(hi);
    check("R7 duty at 0", hi, 0);
    tach_en = 1'b0;
    step_edges(1200);
    check("R9 no stall at level 0", stall_o, 0);

    temp_i = 16'd80;
    wr(3'd2, {8'd224, 8'd50});
    step_edges(20);
    check("R4 floor raises held level", level_o, 50);

    wr(3'd6, 16'd0);                     // unmapped address
    step_edges(20);
    check("R6 unmapped write ignored", level_o, 50);

    rst_ni = 1'b0;
    step_edges(2);
    check("R1 level after reset", level_o, 224);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule